// File: doc/BRIEF.md
# Hierarchical Route Lookup

This block sits at one input port of a seven-port torus router. Each incoming packet header carries a destination node identifier. The block splits that identifier into a partition number (the upper bits) and a node index inside the partition (the lower bits). It then returns the output port and virtual channel the packet should take. If the destination lies in another partition, a small global table with one entry per partition supplies the route. If the destination is in the router's own partition, a larger local table indexed by the node index supplies it. This avoids a single flat table that covers every node in the machine.

Software programs both tables, the router's own partition number, the direction this input faces, and the map from output port to direction. It does this through a one-cycle write strobe with a 2-bit target select. Every lookup returns its result exactly one cycle after the header strobe. The result carries two error flags. One marks an unprogrammed or unusable entry. The other marks a route that would send the packet back along the link it arrived on.

Top module: `route_lookup`

## Requirements
- R1: After reset, `rsp_valid_o` is low, the own partition is 0, every table entry is invalid so every lookup reports a miss, the input faces direction 0 (processor), and port n maps to direction n.
- R2: When `hdr_dest_i[DEST_W-1 -: PART_W]` differs from the own partition, the route comes from the global entry indexed by those bits, and `rsp_global_o` is 1.
- R3: When the partition bits equal the own partition, the route comes from the local entry indexed by `hdr_dest_i[LOCAL_AW-1:0]`, and `rsp_global_o` is 0.
- R4: Table data is written as `wr_data_i` with bit 5 = valid, bits [4:2] = output port, and bits [1:0] = virtual channel. A hit on a valid entry returns that port and channel with both error flags low.
- R5: A hit on an entry whose valid bit is 0, or whose port code is 7, raises `rsp_miss_o`. In that case `rsp_port_o` and `rsp_vc_o` are 0 and `rsp_turn_err_o` is 0.
- R6: `rsp_valid_o` is high in exactly the cycle after each cycle in which `hdr_valid_i` is high. The error flags are low whenever `rsp_valid_o` is low.
- R7: A write takes effect on the following cycle. A lookup in the same cycle as a write to its entry returns the old contents.
- R8: When the input faces a network direction (1 to 6) and the selected port maps to that same direction, `rsp_turn_err_o` is raised and port and channel are 0.
- R9: `wr_sel_i` = 3 writes the direction of port `wr_addr_i[2:0]` from `wr_data_i[2:0]`. Direction codes are 0 processor, 1 +x, 2 -x, 3 +y, 4 -y, 5 +z, 6 -z.
- R10: `wr_sel_i` = 2 writes the own partition from `wr_data_i[2:0]` and the facing direction from `wr_data_i[5:3]`. `wr_sel_i` = 0 writes local entry `wr_addr_i`, and `wr_sel_i` = 1 writes global entry `wr_addr_i[2:0]`.
- R11: An input facing direction 0 never raises a turn error, even when the selected port maps to direction 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 local, 1 global, 2 config, 3 port map |
| wr_addr_i | input | LOCAL_AW | Entry or port index |
| wr_data_i | input | 6 | Write data |
| hdr_valid_i | input | 1 | Header destination present |
| hdr_dest_i | input | PART_W+LOCAL_AW | Destination node identifier |
| rsp_valid_o | output | 1 | Lookup result present |
| rsp_port_o | output | 3 | Output port, 0 on error |
| rsp_vc_o | output | 2 | Virtual channel, 0 on error |
| rsp_global_o | output | 1 | Result came from the global table |
| rsp_miss_o | output | 1 | Entry invalid or port code unusable |
| rsp_turn_err_o | output | 1 | Route would reverse along the arrival link |

## Verification
The hardest case to reach is a turn violation. It needs three pieces of state to line up at once: a valid entry, a port whose mapped direction matches the facing, and a facing other than the processor. The bench builds a small configuration with a 4-bit local index, which gives 128 destinations. It fills the tables with arithmetic patterns that place every port code, including 7, in both tables. It then sweeps all destinations under several combinations of own partition, facing and remapped ports, so both the matching and non-matching directions are covered. A write and a lookup to the same entry are also issued in one cycle to expose the old-versus-new contents.

// File: rtl/rl_pkg.sv
`timescale 1ns/1ps
package rl_pkg;
  localparam int PORT_W    = 3;
  localparam int VC_W      = 2;
  localparam int DIR_W     = 3;
  localparam int NUM_PORTS = 7;
  localparam int ENTRY_W   = 1 + PORT_W + VC_W;

  localparam logic [DIR_W-1:0]  DIR_PROC  = '0;
  localparam logic [PORT_W-1:0] PORT_NONE = '1;

  typedef enum logic [1:0] {
    SEL_LOCAL  = 2'd0,
    SEL_GLOBAL = 2'd1,
    SEL_CFG    = 2'd2,
    SEL_PMAP   = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic              valid;
    logic [PORT_W-1:0] port;
    logic [VC_W-1:0]   vc;
  } entry_t;
endpackage

// File: rtl/rl_table.sv
`timescale 1ns/1ps
module rl_table
  import rl_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  entry_t        wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output entry_t        rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PL_W  = PORT_W + VC_W;

  logic [DEPTH-1:0] vld_q;
  logic [PL_W-1:0]  mem_q [DEPTH];

  // valid bits reset; payload does not need to
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (wr_en_i) vld_q[wr_addr_i] <= wr_data_i.valid;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= {wr_data_i.port, wr_data_i.vc};
  end

  always_comb begin
    rd_data_o.valid = vld_q[rd_addr_i];
    {rd_data_o.port, rd_data_o.vc} = mem_q[rd_addr_i];
  end

  AST_WR_VALID_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_addr_i)] == $past(wr_data_i.valid)); // R4

endmodule

// File: rtl/rl_cfg.sv
`timescale 1ns/1ps
module rl_cfg
  import rl_pkg::*;
#(
  parameter int PART_W = 3,
  parameter int AW     = 12
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [1:0]                         wr_sel_i,
  input  logic [AW-1:0]                      wr_addr_i,
  input  logic [ENTRY_W-1:0]                 wr_data_i,
  output logic [PART_W-1:0]                  part_o,
  output logic [DIR_W-1:0]                   face_o,
  output logic [NUM_PORTS-1:0][DIR_W-1:0]    map_o
);
  logic cfg_we, map_we;
  assign cfg_we = wr_en_i && (wr_sel_i == SEL_CFG);
  assign map_we = wr_en_i && (wr_sel_i == SEL_PMAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_o <= '0;
      face_o <= DIR_PROC;
    end else if (cfg_we) begin
      part_o <= wr_data_i[PART_W-1:0];
      face_o <= wr_data_i[ENTRY_W-1 -: DIR_W];
    end
  end

  // identity map out of reset; index 7 has no port and is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PORTS; i++) map_o[i] <= DIR_W'(i);
    end else if (map_we) begin
      for (int i = 0; i < NUM_PORTS; i++)
        if (wr_addr_i[PORT_W-1:0] == PORT_W'(i)) map_o[i] <= wr_data_i[DIR_W-1:0];
    end
  end

  AST_PART_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we |=> $stable(part_o) && $stable(face_o)); // R10
  AST_MAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_we |=> $stable(map_o)); // R9

endmodule

// File: rtl/rl_turn_chk.sv
`timescale 1ns/1ps
module rl_turn_chk
  import rl_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  logic [DIR_W-1:0] face_i,
  input  logic [DIR_W-1:0] out_dir_i,
  output logic             viol_o
);
  generate
    if (ENABLE) begin : g_chk
      // leaving through the side it entered from reverses the packet
      assign viol_o = (face_i != DIR_PROC) && (out_dir_i == face_i);
    end else begin : g_off
      logic unused;
      assign unused = ^{face_i, out_dir_i};
      assign viol_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/route_lookup.sv
`timescale 1ns/1ps
module route_lookup
  import rl_pkg::*;
#(
  parameter int PART_W     = 3,
  parameter int LOCAL_AW   = 12,
  parameter bit TURN_CHECK = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [1:0]                 wr_sel_i,
  input  logic [LOCAL_AW-1:0]        wr_addr_i,
  input  logic [5:0]                 wr_data_i,
  input  logic                       hdr_valid_i,
  input  logic [PART_W+LOCAL_AW-1:0] hdr_dest_i,
  output logic                       rsp_valid_o,
  output logic [2:0]                 rsp_port_o,
  output logic [1:0]                 rsp_vc_o,
  output logic                       rsp_global_o,
  output logic                       rsp_miss_o,
  output logic                       rsp_turn_err_o
);
  localparam int DEST_W = PART_W + LOCAL_AW;

  logic [PART_W-1:0]                    own_part;
  logic [DIR_W-1:0]                     face;
  logic [NUM_PORTS-1:0][DIR_W-1:0]      pmap;
  entry_t                               wr_ent, g_ent, l_ent, sel_ent;
  logic [PART_W-1:0]                    dest_part;
  logic [LOCAL_AW-1:0]                  dest_node;
  logic                                 use_glob, miss, turn;
  logic [DIR_W-1:0]                     out_dir;

  assign wr_ent    = entry_t'(wr_data_i);
  assign dest_part = hdr_dest_i[DEST_W-1 -: PART_W];
  assign dest_node = hdr_dest_i[LOCAL_AW-1:0];

  rl_cfg #(.PART_W(PART_W), .AW(LOCAL_AW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .part_o    (own_part),
    .face_o    (face),
    .map_o     (pmap)
  );

  rl_table #(.AW(PART_W)) u_glob (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i && (wr_sel_i == SEL_GLOBAL)),
    .wr_addr_i (wr_addr_i[PART_W-1:0]),
    .wr_data_i (wr_ent),
    .rd_addr_i (dest_part),
    .rd_data_o (g_ent)
  );

  rl_table #(.AW(LOCAL_AW)) u_local (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i && (wr_sel_i == SEL_LOCAL)),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_ent),
    .rd_addr_i (dest_node),
    .rd_data_o (l_ent)
  );

  assign use_glob = (dest_part != own_part);
  assign sel_ent  = use_glob ? g_ent : l_ent;
  assign miss     = !sel_ent.valid || (sel_ent.port == PORT_NONE);

  always_comb begin
    out_dir = DIR_PROC;
    for (int i = 0; i < NUM_PORTS; i++)
      if (sel_ent.port == PORT_W'(i)) out_dir = pmap[i];
  end

  logic viol;
  rl_turn_chk #(.ENABLE(TURN_CHECK)) u_turn (
    .face_i    (face),
    .out_dir_i (out_dir),
    .viol_o    (viol)
  );
  assign turn = !miss && viol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_port_o     <= '0;
      rsp_vc_o       <= '0;
      rsp_global_o   <= 1'b0;
      rsp_miss_o     <= 1'b0;
      rsp_turn_err_o <= 1'b0;
    end else begin
      rsp_valid_o    <= hdr_valid_i;
      rsp_global_o   <= hdr_valid_i && use_glob;
      rsp_miss_o     <= hdr_valid_i && miss;
      rsp_turn_err_o <= hdr_valid_i && turn;
      if (hdr_valid_i && !miss && !turn) begin
        rsp_port_o <= sel_ent.port;
        rsp_vc_o   <= sel_ent.vc;
      end else begin
        rsp_port_o <= '0;
        rsp_vc_o   <= '0;
      end
    end
  end

  AST_RSP_FOLLOWS_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> rsp_valid_o); // R6
  AST_RSP_NEEDS_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(hdr_valid_i)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_miss_o && !rsp_turn_err_o && !rsp_global_o); // R6
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_miss_o && rsp_turn_err_o)); // R8
  AST_ERR_NO_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_miss_o || rsp_turn_err_o) |-> rsp_port_o == '0 && rsp_vc_o == '0); // R5
  AST_NO_PORT7_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_port_o != PORT_NONE); // R5

endmodule

// File: tb/sim_route_lookup.sv
`timescale 1ns/1ps
module sim_route_lookup;
  localparam int PW = 3;
  localparam int LW = 4;
  localparam int DW = PW + LW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_sel_i = '0;
  logic [LW-1:0] wr_addr_i = '0;
  logic [5:0]    wr_data_i = '0;
  logic          hdr_valid_i = 1'b0;
  logic [DW-1:0] hdr_dest_i = '0;
  logic          rsp_valid_o, rsp_global_o, rsp_miss_o, rsp_turn_err_o;
  logic [2:0]    rsp_port_o;
  logic [1:0]    rsp_vc_o;

  always #10 clk = ~clk;

  route_lookup #(.PART_W(PW), .LOCAL_AW(LW), .TURN_CHECK(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .hdr_valid_i(hdr_valid_i),
    .hdr_dest_i(hdr_dest_i), .rsp_valid_o(rsp_valid_o), .rsp_port_o(rsp_port_o),
    .rsp_vc_o(rsp_vc_o), .rsp_global_o(rsp_global_o), .rsp_miss_o(rsp_miss_o),
    .rsp_turn_err_o(rsp_turn_err_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [5:0] gm [8];
  logic [5:0] lm [16];
  logic [2:0] part_m, face_m;
  logic [2:0] map_m [7];

  // expected response word {valid, global, miss, turn, port, vc}
  function automatic logic [8:0] model(input logic [DW-1:0] d);
    logic [2:0] p, ep, dir;
    logic       g, miss, turn;
    logic [5:0] e;
    p = d[DW-1 -: PW];
    g = (p != part_m);
    e = g ? gm[p] : lm[d[LW-1:0]];
    ep = e[4:2];
    miss = !e[5] || (ep == 3'd7);
    dir = (ep < 3'd7) ? map_m[ep] : 3'd0;
    turn = !miss && (face_m != 3'd0) && (dir == face_m);
    return {1'b1, g, miss, turn, (miss || turn) ? 5'd0 : e[4:0]};
  endfunction

  function automatic logic [8:0] got();
    return {rsp_valid_o, rsp_global_o, rsp_miss_o, rsp_turn_err_o, rsp_port_o, rsp_vc_o};
  endfunction

  task automatic check(input logic [8:0] exp, input string req, input logic [DW-1:0] d);
    n_chk++;
    if (got() !== exp) begin
      n_bad++;
      $display("FAIL %s dest=%0h actual=%b expected=%b", req, d, got(), exp);
    end
  endtask

  task automatic look(input logic [DW-1:0] d, input string req);
    logic [8:0] exp;
    exp = model(d);
    hdr_valid_i = 1'b1; hdr_dest_i = d;
    @(negedge clk);
    hdr_valid_i = 1'b0;
    check(exp, req, d);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [LW-1:0] a, input logic [5:0] dat);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_addr_i = a; wr_data_i = dat;
    @(negedge clk);
    wr_en_i = 1'b0;
    case (sel)
      2'd0: lm[a] = dat;
      2'd1: gm[a[2:0]] = dat;
      2'd2: begin part_m = dat[2:0]; face_m = dat[5:3]; end
      default: if (a[2:0] < 3'd7) map_m[a[2:0]] = dat[2:0];
    endcase
  endtask

  task automatic sweep(input string req);
    for (int d = 0; d < (1 << DW); d++) look(DW'(d), req);
  endtask

  initial begin
    logic [8:0] exp;
    for (int i = 0; i < 8; i++) gm[i] = 6'd0;
    for (int i = 0; i < 16; i++) lm[i] = 6'd0;
    for (int i = 0; i < 7; i++) map_m[i] = 3'(i);
    part_m = 3'd0; face_m = 3'd0;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(9'd0, "R1 reset idle", '0);
    sweep("R1 reset all miss, R2/R3 table select");

    // R4 R5: every port code incl. 7 and invalid entries
    for (int i = 0; i < 16; i++)
      wr(2'd0, LW'(i), {(i % 5) != 0, 3'(i % 8), 2'((i * 3) % 4)});
    for (int i = 0; i < 8; i++)
      wr(2'd1, LW'(i), {i != 6, 3'(7 - i), 2'(i % 4)});
    sweep("R4/R5/R11 own part 0 facing processor");

    // R10 R8: partition 5, facing +x; port 1 reverses
    wr(2'd2, '0, {3'd1, 3'd5});
    sweep("R10/R8 part 5 facing +x");

    // R9: remap ports, facing +y, partition 2
    wr(2'd3, LW'(5), 6'd3);
    wr(2'd3, LW'(3), 6'd5);
    wr(2'd2, '0, {3'd3, 3'd2});
    sweep("R9/R8 remap facing +y");

    // R7: write and lookup to same local entry in one cycle
    wr(2'd2, '0, {3'd0, 3'd2});
    exp = model({3'd2, 4'd9});
    wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_addr_i = 4'd9; wr_data_i = {1'b1, 3'd4, 2'd2};
    hdr_valid_i = 1'b1; hdr_dest_i = {3'd2, 4'd9};
    @(negedge clk);
    wr_en_i = 1'b0; hdr_valid_i = 1'b0;
    check(exp, "R7 same-cycle old contents", {3'd2, 4'd9});
    lm[9] = {1'b1, 3'd4, 2'd2};
    look({3'd2, 4'd9}, "R7 new contents next cycle");

    // R6: back-to-back then idle
    hdr_valid_i = 1'b1; hdr_dest_i = {3'd2, 4'd1};
    @(negedge clk);
    check(model({3'd2, 4'd1}), "R6 back-to-back first", {3'd2, 4'd1});
    exp = model({3'd6, 4'd0});
    hdr_dest_i = {3'd6, 4'd0};
    @(negedge clk);
    hdr_valid_i = 1'b0;
    check(exp, "R6 back-to-back second", {3'd6, 4'd0});
    @(negedge clk);
    check(9'd0, "R6 idle after lookups", '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule